// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer whose producer and consumer run on independent clocks. Words enter on the write clock while the active-low write enable is asserted and leave on the read clock while the active-low read enable is asserted. The read and write pointers travel between the two clock domains in Gray code through synchronizer chains. Each flag is computed in the domain that uses it, so empty and full can only report late, never early.

Two threshold registers set where the almost-empty and almost-full flags switch. They share the data path. With the load strobe low, a write-enabled cycle stores the low data bits into a threshold register instead of queueing a word. A read-enabled cycle with the load strobe low returns a threshold on the output. An internal toggle steps through the two thresholds, almost-empty first.

A mode pin is sampled during reset and picks one of two output styles. The standard style presents a word only after a read request. The fall-through style puts the oldest word on the output by itself. An output enable blanks the data output, which models a tri-state bus as a valid mask.

Top module: `fifo_pf`

## Requirements
- R1: While `rst_n` is low, both pointers return to location zero; in standard mode `empty_n`=0, `full_n`=1, `almost_empty_n`=0, `almost_full_n`=1 and `half_full_n`=1 once reset is released with no traffic; both thresholds reload to their reset value (127 by default).
- R2: A word is stored on a rising `wr_clk` edge only when `wr_en_n`=0, `ld_n`=1 and the queue is not full.
- R3: With the queue full (level equal to DEPTH), a write request leaves the contents and the write pointer unchanged; in standard mode `full_n` is 0 exactly at level DEPTH.
- R4: Words leave in the order written. In standard mode a read on a rising `rd_clk` edge with `rd_en_n`=0, `ld_n`=1 and a non-empty queue loads the oldest word into the output register. A read request while empty changes nothing. `empty_n` is 0 when no word is stored.
- R5: In standard mode, while `rd_en_n` is 1, the output register keeps its value.
- R6: With `ld_n`=0 and `wr_en_n`=0, bits [11:0] of `din` go into a threshold register on the `wr_clk` edge, with no word queued; the first such load after reset sets the almost-empty threshold, the second the almost-full threshold, alternating afterwards.
- R7: With `ld_n`=0 and `rd_en_n`=0 in standard mode, the output register takes a threshold, zero-extended from bit 12 up, on the `rd_clk` edge: almost-empty first, then almost-full, alternating; reset restarts the order.
- R8: `almost_empty_n` is 0 when the stored level is less than or equal to the almost-empty threshold, 1 otherwise.
- R9: `almost_full_n` is 0 when level plus the almost-full threshold is at least DEPTH, 1 otherwise.
- R10: `half_full_n` is 0 when the level exceeds DEPTH/2, 1 otherwise.
- R11: In fall-through mode the oldest word appears on `dout` with no read request. `empty_n`=0 means a valid word is on the output and 1 means none. `full_n`=0 means space to write and 1 means full. A read request consumes the shown word and the next word, if any, replaces it on the same edge.
- R12: While `oe_n` is 1, `dout` reads all zeros and `dout_drv` is 0; while 0, `dout` shows the output register and `dout_drv` is 1.
- R13: `fwft_sel` (1 = fall-through, 0 = standard) is captured only while `rst_n` is low; changing it afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwft_sel | input | 1 | Output style captured in reset: 1 fall-through, 0 standard |
| wr_en_n | input | 1 | Write enable, active low |
| ld_n | input | 1 | Threshold access strobe, active low |
| din | input | 18 | Write data; bits [11:0] also carry threshold values |
| rd_en_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 18 | Read data, zero while blanked |
| dout_drv | output | 1 | High while the output would be driven |
| empty_n | output | 1 | Standard: low when empty; fall-through: low when output holds data |
| full_n | output | 1 | Standard: low when full; fall-through: low when space is free |
| almost_empty_n | output | 1 | Low at or below the almost-empty threshold |
| almost_full_n | output | 1 | Low within the almost-full threshold of full |
| half_full_n | output | 1 | Low above half occupancy |

## Verification
Results on the write side (`full_n`, `almost_full_n`, `half_full_n`) change on the same `wr_clk` edge that stores the word. Results that depend on the far pointer (`empty_n`, `almost_empty_n`, fall-through data) need two synchronizer edges and one more register edge, so they settle at most three read-clock edges after the write. Read data and threshold readback appear on the `rd_clk` edge of the request. The bench drives on falling edges and samples on the next falling edge for same-edge results. Before it checks any flag that crosses domains, it idles six to eight cycles, and in random traffic it acts only on flags sampled between edges.

// File: rtl/fifo_pf_pkg.sv
`timescale 1ns/1ps
package fifo_pf_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } out_mode_e;

   // Gray to binary over a 32-bit container; callers truncate.
   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/fifo_pf_sync.sv
`timescale 1ns/1ps
module fifo_pf_sync #(
   parameter int WIDTH  = 11,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fifo_pf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fifo_pf_wside.sv
`timescale 1ns/1ps
module fifo_pf_wside
   import fifo_pf_pkg::*;
#(
   parameter int AW          = 10,
   parameter int OFF_W       = 12,
   parameter int AE_RESET    = 127,
   parameter int AF_RESET    = 127,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_sel,
   input  logic             wr_en_n,
   input  logic             ld_n,
   input  logic [OFF_W-1:0] din_lo,
   input  logic [AW:0]      rgray_x,
   output logic             mem_we,
   output logic [AW-1:0]    waddr,
   output logic [AW:0]      wgray,
   output logic [AW:0]      wptr,
   output logic [AW:0]      level,
   output logic             full_i,
   output logic             full_n,
   output logic             almost_full_n,
   output logic             half_full_n,
   output logic [OFF_W-1:0] off_ae,
   output logic [OFF_W-1:0] off_af
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;
   localparam int CW    = ((PW > OFF_W) ? PW : OFF_W) + 1;

   out_mode_e        mode_q;
   logic [PW-1:0]    wptr_q, wgray_q, wptr_nxt, rgray_s, rptr_s;
   logic [OFF_W-1:0] off_ae_q, off_af_q;
   logic             sel_af_q;
   logic             push, ld_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= out_mode_e'(mode_sel);
   end

   fifo_pf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rgray_x),
      .q     (rgray_s)
   );

   assign rptr_s   = PW'(gray_to_bin(32'(rgray_s)));
   assign level    = wptr_q - rptr_s;
   assign full_i   = (level == PW'(DEPTH));
   assign push     = !wr_en_n && ld_n && !full_i;
   assign ld_wr    = !wr_en_n && !ld_n;
   assign wptr_nxt = wptr_q + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         wgray_q <= '0;
      end else if (push) begin
         wptr_q  <= wptr_nxt;
         wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_ae_q <= OFF_W'(AE_RESET);
         off_af_q <= OFF_W'(AF_RESET);
         sel_af_q <= 1'b0;
      end else if (ld_wr) begin
         if (sel_af_q) off_af_q <= din_lo;
         else          off_ae_q <= din_lo;
         sel_af_q <= !sel_af_q;
      end
   end

   assign mem_we        = push;
   assign waddr         = wptr_q[AW-1:0];
   assign wgray         = wgray_q;
   assign wptr          = wptr_q;
   assign full_n        = (mode_q == MODE_FWFT) ? full_i : !full_i;
   assign almost_full_n = !((CW'(level) + CW'(off_af_q)) >= CW'(DEPTH));
   assign half_full_n   = !(level > PW'(DEPTH / 2));
   assign off_ae        = off_ae_q;
   assign off_af        = off_af_q;

endmodule

// File: rtl/fifo_pf_rside.sv
`timescale 1ns/1ps
module fifo_pf_rside
   import fifo_pf_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int AW          = 10,
   parameter int OFF_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_sel,
   input  logic              rd_en_n,
   input  logic              ld_n,
   input  logic [AW:0]       wgray_x,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [OFF_W-1:0]  off_ae,
   input  logic [OFF_W-1:0]  off_af,
   output logic [AW-1:0]     raddr,
   output logic [AW:0]       rgray,
   output logic [AW:0]       rptr,
   output logic [AW:0]       mem_words,
   output logic              r_empty,
   output logic              fwft,
   output logic [DATA_W-1:0] dout_q,
   output logic              empty_n,
   output logic              almost_empty_n
);

   localparam int PW = AW + 1;
   localparam int CW = ((PW > OFF_W) ? PW : OFF_W) + 1;

   out_mode_e         mode_q;
   logic [PW-1:0]     rptr_q, rgray_q, rptr_nxt, wgray_s, wptr_s, ae_level;
   logic [DATA_W-1:0] data_q;
   logic              out_vld_q, rb_af_q;
   logic              std_pop, rb_req, fw_take, fw_load, pop, is_fwft;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= out_mode_e'(mode_sel);
   end

   assign is_fwft = (mode_q == MODE_FWFT);

   fifo_pf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wgray_x),
      .q     (wgray_s)
   );

   assign wptr_s    = PW'(gray_to_bin(32'(wgray_s)));
   assign mem_words = wptr_s - rptr_q;
   assign r_empty   = (mem_words == '0);

   assign std_pop  = !is_fwft && !rd_en_n && ld_n && !r_empty;
   assign rb_req   = !is_fwft && !rd_en_n && !ld_n;
   assign fw_take  = is_fwft && !rd_en_n && ld_n && out_vld_q;
   assign fw_load  = is_fwft && !r_empty && (!out_vld_q || fw_take);
   assign pop      = std_pop || fw_load;
   assign rptr_nxt = rptr_q + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q  <= '0;
         rgray_q <= '0;
      end else if (pop) begin
         rptr_q  <= rptr_nxt;
         rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         out_vld_q <= 1'b0;
         rb_af_q   <= 1'b0;
      end else begin
         if (pop) begin
            data_q <= mem_rdata;
         end else if (rb_req) begin
            data_q <= DATA_W'(rb_af_q ? off_af : off_ae);
         end
         if (rb_req)       rb_af_q   <= !rb_af_q;
         if (fw_load)      out_vld_q <= 1'b1;
         else if (fw_take) out_vld_q <= 1'b0;
      end
   end

   assign ae_level       = mem_words + PW'(is_fwft && out_vld_q);
   assign almost_empty_n = !(CW'(ae_level) <= CW'(off_ae));
   assign empty_n        = is_fwft ? !out_vld_q : !r_empty;
   assign raddr          = rptr_q[AW-1:0];
   assign rgray          = rgray_q;
   assign rptr           = rptr_q;
   assign fwft           = is_fwft;
   assign dout_q         = data_q;

endmodule

// File: rtl/fifo_pf.sv
`timescale 1ns/1ps
module fifo_pf #(
   parameter int DATA_W      = 18,
   parameter int DEPTH       = 1024,
   parameter int OFF_W       = 12,
   parameter int AE_RESET    = 127,
   parameter int AF_RESET    = 127,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              fwft_sel,
   input  logic              wr_en_n,
   input  logic              ld_n,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_en_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_drv,
   output logic              empty_n,
   output logic              full_n,
   output logic              almost_empty_n,
   output logic              almost_full_n,
   output logic              half_full_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fifo_pf: DEPTH must be a power of two, at least 4");
   end
   if (OFF_W > DATA_W || OFF_W < 1) begin : g_bad_offw
      $error("fifo_pf: OFF_W must lie in 1..DATA_W");
   end
   if (AE_RESET >= DEPTH || AF_RESET >= DEPTH || AE_RESET < 0 || AF_RESET < 0) begin : g_bad_reset
      $error("fifo_pf: threshold reset values must lie below DEPTH");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] mem_rdata, dout_q;
   logic [AW-1:0]     waddr, raddr;
   logic [PW-1:0]     wgray, rgray, w_ptr, r_ptr, w_level, r_level;
   logic [OFF_W-1:0]  off_ae, off_af;
   logic              mem_we, w_full, r_empty, r_fwft;

   fifo_pf_wside #(
      .AW(AW), .OFF_W(OFF_W), .AE_RESET(AE_RESET), .AF_RESET(AF_RESET),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_wside (
      .clk           (wr_clk),
      .rst_n         (rst_n),
      .mode_sel      (fwft_sel),
      .wr_en_n       (wr_en_n),
      .ld_n          (ld_n),
      .din_lo        (din[OFF_W-1:0]),
      .rgray_x       (rgray),
      .mem_we        (mem_we),
      .waddr         (waddr),
      .wgray         (wgray),
      .wptr          (w_ptr),
      .level         (w_level),
      .full_i        (w_full),
      .full_n        (full_n),
      .almost_full_n (almost_full_n),
      .half_full_n   (half_full_n),
      .off_ae        (off_ae),
      .off_af        (off_af)
   );

   fifo_pf_rside #(
      .DATA_W(DATA_W), .AW(AW), .OFF_W(OFF_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_rside (
      .clk            (rd_clk),
      .rst_n          (rst_n),
      .mode_sel       (fwft_sel),
      .rd_en_n        (rd_en_n),
      .ld_n           (ld_n),
      .wgray_x        (wgray),
      .mem_rdata      (mem_rdata),
      .off_ae         (off_ae),
      .off_af         (off_af),
      .raddr          (raddr),
      .rgray          (rgray),
      .rptr           (r_ptr),
      .mem_words      (r_level),
      .r_empty        (r_empty),
      .fwft           (r_fwft),
      .dout_q         (dout_q),
      .empty_n        (empty_n),
      .almost_empty_n (almost_empty_n)
   );

   always_ff @(posedge wr_clk) begin
      if (mem_we) mem_q[waddr] <= din;
   end

   assign mem_rdata = mem_q[raddr];
   assign dout      = oe_n ? '0 : dout_q;
   assign dout_drv  = !oe_n;

endmodule

// File: rtl/fifo_pf_chk.sv
`timescale 1ns/1ps
module fifo_pf_chk #(
   parameter int DATA_W = 18,
   parameter int AW     = 10
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              wr_en_n,
   input logic              rd_en_n,
   input logic              half_full_n,
   input logic              almost_empty_n,
   input logic [AW:0]       w_level,
   input logic [AW:0]       r_level,
   input logic [AW:0]       w_ptr,
   input logic [AW:0]       r_ptr,
   input logic              w_full,
   input logic              r_empty,
   input logic              r_fwft,
   input logic [DATA_W-1:0] dout_q
);

   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   // R3: the write-side level never passes the capacity
   p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      w_level <= PW'(DEPTH));

   // R3: a write request against a full queue leaves the pointer alone
   p_full_blocks_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (w_full && !wr_en_n) |=> $stable(w_ptr));

   // R4: the read-side count never passes the capacity
   p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      r_level <= PW'(DEPTH));

   // R4: a read request against an empty queue leaves the pointer alone
   p_empty_blocks_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (r_empty && !rd_en_n) |=> $stable(r_ptr));

   // R5: standard-mode output register holds without a read request
   p_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!r_fwft && rd_en_n) |=> $stable(dout_q));

   // R8: an empty standard-mode queue is always almost empty
   p_ae_on_empty_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (r_empty && !r_fwft) |-> !almost_empty_n);

   // R10: a full queue is always past half
   p_half_on_full_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
      w_full |-> !half_full_n);

endmodule

bind fifo_pf fifo_pf_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
   .wr_clk         (wr_clk),
   .rd_clk         (rd_clk),
   .rst_n          (rst_n),
   .wr_en_n        (wr_en_n),
   .rd_en_n        (rd_en_n),
   .half_full_n    (half_full_n),
   .almost_empty_n (almost_empty_n),
   .w_level        (w_level),
   .r_level        (r_level),
   .w_ptr          (w_ptr),
   .r_ptr          (r_ptr),
   .w_full         (w_full),
   .r_empty        (r_empty),
   .r_fwft         (r_fwft),
   .dout_q         (dout_q)
);

// File: tb/fifo_pf_bench.sv
`timescale 1ns/1ps
module fifo_pf_bench;

   localparam int DW    = 18;
   localparam int DEPTH = 1024;
   localparam int OAE   = 5;
   localparam int OAF   = 9;

   logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b1, fwft_sel = 1'b0;
   logic          wr_en_n = 1'b1, ld_n = 1'b1, rd_en_n = 1'b1, oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_drv, empty_n, full_n, almost_empty_n, almost_full_n, half_full_n;

   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;
   logic [DW-1:0] model_q[$];

   fifo_pf u_fifo_pf (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_sel(fwft_sel),
      .wr_en_n(wr_en_n), .ld_n(ld_n), .din(din), .rd_en_n(rd_en_n), .oe_n(oe_n),
      .dout(dout), .dout_drv(dout_drv), .empty_n(empty_n), .full_n(full_n),
      .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
      .half_full_n(half_full_n)
   );

   always #2.5 wr_clk = ~wr_clk;
   initial begin
      #1.1;
      forever #2.5 rd_clk = ~rd_clk;
   end

   function automatic bit exp_ae_n(int lvl, int off);
      return !(lvl <= off);
   endfunction
   function automatic bit exp_af_n(int lvl, int off);
      return !(lvl + off >= DEPTH);
   endfunction
   function automatic bit exp_hf_n(int lvl);
      return !(lvl > DEPTH / 2);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge wr_clk);
   endtask

   task automatic do_reset(input logic mode);
      @(negedge wr_clk);
      rst_n = 1'b0; fwft_sel = mode;
      wr_en_n = 1'b1; rd_en_n = 1'b1; ld_n = 1'b1;
      idle(4);
      rst_n = 1'b1;
      model_q.delete();
      idle(2);
   endtask

   task automatic wr_push(input logic [DW-1:0] d);
      @(negedge wr_clk);
      din = d; wr_en_n = 1'b0; ld_n = 1'b1;
      @(negedge wr_clk);
      wr_en_n = 1'b1;
   endtask

   task automatic wr_load(input logic [DW-1:0] d);
      @(negedge wr_clk);
      din = d; wr_en_n = 1'b0; ld_n = 1'b0;
      @(negedge wr_clk);
      wr_en_n = 1'b1; ld_n = 1'b1;
   endtask

   task automatic rd_pop(output logic [DW-1:0] q);
      @(negedge rd_clk);
      rd_en_n = 1'b0; ld_n = 1'b1;
      @(negedge rd_clk);
      rd_en_n = 1'b1;
      q = dout;
   endtask

   task automatic rd_load(output logic [DW-1:0] q);
      @(negedge rd_clk);
      rd_en_n = 1'b0; ld_n = 1'b0;
      @(negedge rd_clk);
      rd_en_n = 1'b1; ld_n = 1'b1;
      q = dout;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      logic [DW-1:0] q, w, held;
      int lvl;
      void'($urandom(32'd20240517));
      #1;

      // ---------------- standard mode ----------------
      do_reset(1'b0);
      check(empty_n == 1'b0,        "R1 empty_n",        empty_n, 0);
      check(full_n == 1'b1,         "R1 full_n",         full_n, 1);
      check(almost_empty_n == 1'b0, "R1 almost_empty_n", almost_empty_n, 0);
      check(almost_full_n == 1'b1,  "R1 almost_full_n",  almost_full_n, 1);
      check(half_full_n == 1'b1,    "R1 half_full_n",    half_full_n, 1);

      rd_load(q); check(q == 18'd127, "R1 R7 default almost-empty threshold", q, 127);
      rd_load(q); check(q == 18'd127, "R1 R7 default almost-full threshold",  q, 127);

      wr_load(18'h3F000 | 18'(OAE));   // upper bits must be ignored
      wr_load(18'(OAF));
      idle(6);
      check(empty_n == 1'b0, "R6 threshold load queues no word", empty_n, 0);
      rd_load(q); check(q == 18'(OAE), "R6 R7 almost-empty threshold", q, OAE);
      rd_load(q); check(q == 18'(OAF), "R6 R7 almost-full threshold",  q, OAF);

      // short burst, standard read order
      for (int i = 0; i < 8; i++) begin
         w = 18'($urandom);
         wr_push(w);
         model_q.push_back(w);
      end
      idle(8);
      check(empty_n == 1'b1, "R2 R4 words stored", empty_n, 1);
      check(almost_empty_n == exp_ae_n(8, OAE), "R8 level 8", almost_empty_n, exp_ae_n(8, OAE));
      for (int i = 0; i < 8; i++) begin
         rd_pop(q);
         w = model_q.pop_front();
         check(q == w, "R4 burst order", q, w);
      end
      idle(8);
      check(empty_n == 1'b0, "R4 empty after drain", empty_n, 0);
      check(almost_empty_n == 1'b0, "R8 level 0", almost_empty_n, 0);
      held = dout;
      rd_pop(q);
      check(q == held, "R4 read while empty keeps output", q, held);

      // R5: no read request, output holds
      idle(5);
      check(dout == held, "R5 output held", dout, held);

      // R12: output enable blanks the bus
      @(negedge rd_clk); oe_n = 1'b1;
      @(negedge rd_clk);
      check(dout == '0 && dout_drv == 1'b0, "R12 blanked", {dout_drv, dout}, 0);
      oe_n = 1'b0;
      @(negedge rd_clk);
      check(dout == held && dout_drv == 1'b1, "R12 driven", dout, held);

      // fill to full, boundary flags
      for (int i = 0; i < DEPTH; i++) begin
         w = 18'($urandom);
         wr_push(w);
         model_q.push_back(w);
         lvl = i + 1;
         if (lvl == 5 || lvl == 6 || lvl == 512 || lvl == 513 ||
             lvl == DEPTH - OAF - 1 || lvl == DEPTH - OAF ||
             lvl == DEPTH - 1 || lvl == DEPTH) begin
            idle(6);
            check(almost_empty_n == exp_ae_n(lvl, OAE), "R8 boundary",
                  almost_empty_n, exp_ae_n(lvl, OAE));
            check(almost_full_n == exp_af_n(lvl, OAF), "R9 boundary",
                  almost_full_n, exp_af_n(lvl, OAF));
            check(half_full_n == exp_hf_n(lvl), "R10 boundary",
                  half_full_n, exp_hf_n(lvl));
            check(full_n == (lvl != DEPTH), "R3 full flag",
                  full_n, (lvl != DEPTH));
         end
      end
      wr_push(18'h2AAAA);               // refused: queue is full
      idle(4);
      check(full_n == 1'b0, "R3 still full", full_n, 0);
      for (int i = 0; i < DEPTH; i++) begin
         rd_pop(q);
         w = model_q.pop_front();
         check(q == w, "R4 R3 fill order", q, w);
      end
      idle(8);
      check(empty_n == 1'b0, "R3 refused word not stored", empty_n, 0);
      check(full_n == 1'b1, "R3 not full after drain", full_n, 1);

      // constrained random concurrent traffic
      fork
         begin
            for (int i = 0; i < 700; i++) begin
               @(negedge wr_clk);
               if (($urandom % 10) < 6 && full_n) begin
                  w = 18'($urandom);
                  din = w; wr_en_n = 1'b0;
                  model_q.push_back(w);
               end else begin
                  wr_en_n = 1'b1;
               end
            end
            @(negedge wr_clk);
            wr_en_n = 1'b1;
         end
         begin
            logic [DW-1:0] exp_w;
            bit pend = 1'b0;
            for (int i = 0; i < 700; i++) begin
               @(negedge rd_clk);
               if (pend) check(dout == exp_w, "R4 random order", dout, exp_w);
               pend = 1'b0;
               if (($urandom % 10) < 5 && empty_n) begin
                  rd_en_n = 1'b0;
                  exp_w = model_q.pop_front();
                  pend = 1'b1;
               end else begin
                  rd_en_n = 1'b1;
               end
            end
            @(negedge rd_clk);
            rd_en_n = 1'b1;
            if (pend) check(dout == exp_w, "R4 random order", dout, exp_w);
         end
      join
      idle(8);
      while (model_q.size() > 0) begin
         rd_pop(q);
         w = model_q.pop_front();
         check(q == w, "R4 random drain", q, w);
      end

      // ---------------- fall-through mode ----------------
      do_reset(1'b1);
      fwft_sel = 1'b0;                  // R13: ignored after reset
      idle(2);
      check(full_n == 1'b0,  "R11 R13 space available", full_n, 0);
      check(empty_n == 1'b1, "R11 no word shown", empty_n, 1);
      for (int i = 0; i < 3; i++) begin
         w = 18'($urandom);
         wr_push(w);
         model_q.push_back(w);
      end
      idle(8);
      check(empty_n == 1'b0, "R11 word shown", empty_n, 0);
      check(dout == model_q[0], "R11 R13 first word without read", dout, model_q[0]);
      void'(model_q.pop_front());
      rd_pop(q);
      check(q == model_q[0], "R11 second word", q, model_q[0]);
      void'(model_q.pop_front());
      rd_pop(q);
      check(q == model_q[0], "R11 third word", q, model_q[0]);
      void'(model_q.pop_front());
      rd_pop(q);
      check(empty_n == 1'b1, "R11 no word after last read", empty_n, 1);

      done = 1'b1;
      finish_run();
   end

endmodule